// File: doc/BRIEF.md
# Regulator Configuration Register Bank with I2C Slave

This block is the configuration register bank of a programmable step-down regulator, reached over a two-wire I2C bus. It answers the 7-bit device address 0x60 (0xC0 for a write, 0xC1 for a read). A write carries a register index and one data byte. A read sets the index with a write phase, then uses a repeated START and a read phase that returns one byte. The bank keeps two voltage-setting registers, one per level of the external set-select pin. Each holds an enable bit, a forced-PWM bit and a 6-bit voltage code. A control register holds the output-discharge bit and the 3-bit rising-slew code. Three read-only bytes report identity and the power-good input.

The bus lines are sampled into the system clock through a synchronizer. The system clock must run at least 8 times faster than SCL. START and STOP are recognised from SDA edges while SCL is high. SDA is never driven high. The block only asserts a pull-down request, and it changes that request only while SCL is low. While the chip enable is low, every register is forced to its default and the bus interface stays silent. The register fields drive the regulator control logic directly.

Top module: `vreg_cfg_i2c`

## Requirements
- R1: After reset the outputs show set 0 = 0x28 (bit 7 enable 0, bit 6 forced-PWM 0, code bits 5:0 = 0x28), set 1 = 0xAC (enable 1, forced-PWM 0, code 0x2C), discharge 1 and slew 000.
- R2: A write START, 0xC0, index, data, STOP gets an ACK (SDA low on the ninth clock) for each of the three bytes. Index 0x00 loads set 0 and index 0x01 loads set 1, and the bits map as in R1. Bytes are sent MSB first.
- R3: A read (START, 0xC0, index, repeated START, 0xC1) is acknowledged. The block then returns the indexed byte MSB first, one bit per SCL clock.
- R4: Index 0x02 holds discharge in bit 7 and slew in bits 6:4. Bits 3, 1 and 0 always read 0.
- R5: Writing a 1 to bit 2 of index 0x02 returns every register to its R1 default, whatever the other bits of that byte hold. Bit 2 always reads 0.
- R6: Index 0x03 reads 0x80 and index 0x04 reads 0x01. Writes to them are acknowledged and change nothing.
- R7: Index 0x05 reads the power-good input in bit 7, and bits 6:0 read 0. Writes to it are ignored.
- R8: Indices above 0x05 are acknowledged. Writes to them are discarded and reads from them return 0x00.
- R9: An address byte other than 0xC0 or 0xC1 is not acknowledged and changes no register.
- R10: A byte 00001xxx right after START (the high-speed master code) is not acknowledged. A following repeated START with 0xC0 is decoded normally.
- R11: While the enable input is low, all registers hold their defaults, no byte is acknowledged and SDA is never pulled.
- R12: The pull-down request is raised only for an ACK or a 0 read bit. It changes only while SCL is low, and it is released by the STOP that ends a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Chip enable, synchronous to clk_i; low holds defaults |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| pgood_i | input | 1 | Power-good status reported in index 0x05 |
| sda_pull_o | output | 1 | 1 requests the open-drain pull-down of SDA |
| buck0_on_o | output | 1 | Set 0 regulator enable |
| pwm0_force_o | output | 1 | Set 0 forced-PWM mode |
| vcode0_o | output | 6 | Set 0 voltage code |
| buck1_on_o | output | 1 | Set 1 regulator enable |
| pwm1_force_o | output | 1 | Set 1 forced-PWM mode |
| vcode1_o | output | 6 | Set 1 voltage code |
| discharge_o | output | 1 | Output discharge when off |
| slew_o | output | 3 | Rising-transition slew code |

## Verification
The soft-reset bit and an ordinary field write arrive in the same control byte. The bench therefore writes control bytes that set the reset bit together with non-default discharge and slew values. It first loads both set registers with non-default values. The design is correct only if every output and read-back value equals its default afterwards, so the reset must win over the fields written in that same byte. A second pair of actions can also meet in one cycle: enable going low and a bus write. The bench writes with enable held low and expects a NACK and default outputs.

// File: rtl/vreg_cfg_pkg.sv
`timescale 1ns/1ps
package vreg_cfg_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_SETS = 2;

  localparam logic [NUM_SETS-1:0][REG_W-1:0] SET_DEF = {8'hAC, 8'h28};
  localparam logic             DIS_DEF  = 1'b1;
  localparam logic [2:0]       SLEW_DEF = 3'b000;
  localparam logic [REG_W-1:0] ID_VEND  = 8'h80;
  localparam logic [REG_W-1:0] ID_REV   = 8'h01;

  localparam logic [REG_W-1:0] IDX_CTRL = 8'h02;
  localparam logic [REG_W-1:0] IDX_VEND = 8'h03;
  localparam logic [REG_W-1:0] IDX_REV  = 8'h04;
  localparam logic [REG_W-1:0] IDX_STAT = 8'h05;
  localparam int unsigned      CTRL_RST_BIT = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT} bus_st_e;
  typedef enum logic [1:0] {PH_DEV, PH_IDX, PH_DATA, PH_DONE} rx_ph_e;
endpackage

// File: rtl/vreg_i2c_sync.sv
`timescale 1ns/1ps
module vreg_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/vreg_i2c_engine.sv
`timescale 1ns/1ps
module vreg_i2c_engine
  import vreg_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rdata_i,
  output logic             sda_pull_o,
  output logic             wr_o,
  output logic [REG_W-1:0] idx_o,
  output logic [REG_W-1:0] wdata_o
);
  bus_st_e          st_q;
  rx_ph_e           ph_q;
  logic [3:0]       cnt_q;
  logic [REG_W-1:0] sh_q, tx_q;
  logic             to_tx_q;
  logic             dev_hit, hs_code;

  assign dev_hit = (sh_q[7:1] == DEV_ADDR);
  assign hs_code = (sh_q[7:3] == 5'b00001);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= PH_DEV; cnt_q <= '0;
      sh_q <= '0; tx_q <= '0; to_tx_q <= 1'b0;
      sda_pull_o <= 1'b0; wr_o <= 1'b0; idx_o <= '0; wdata_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        st_q <= ST_RX; ph_q <= PH_DEV; cnt_q <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              unique case (ph_q)
                PH_DEV: begin
                  if (dev_hit && !hs_code) begin
                    sda_pull_o <= 1'b1; st_q <= ST_ACK;
                    to_tx_q <= sh_q[0]; ph_q <= PH_IDX;
                  end else begin
                    st_q <= ST_WAIT;
                  end
                end
                PH_IDX: begin
                  idx_o <= sh_q; sda_pull_o <= 1'b1; st_q <= ST_ACK;
                  to_tx_q <= 1'b0; ph_q <= PH_DATA;
                end
                PH_DATA: begin
                  wr_o <= 1'b1; wdata_o <= sh_q; sda_pull_o <= 1'b1;
                  st_q <= ST_ACK; to_tx_q <= 1'b0; ph_q <= PH_DONE;
                end
                default: st_q <= ST_WAIT;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (to_tx_q) begin
                st_q <= ST_TX; tx_q <= rdata_i; cnt_q <= '0;
                sda_pull_o <= ~rdata_i[7];
              end else begin
                st_q <= ST_RX; sda_pull_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                st_q <= ST_MACK; sda_pull_o <= 1'b0;
              end else begin
                sda_pull_o <= ~tx_q[~cnt_q[2:0]];
              end
            end
          end
          ST_MACK: if (scl_rise_i) st_q <= ST_WAIT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vreg_reg_bank.sv
`timescale 1ns/1ps
module vreg_reg_bank
  import vreg_cfg_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic                            wr_i,
  input  logic [REG_W-1:0]                idx_i,
  input  logic [REG_W-1:0]                wdata_i,
  input  logic                            pgood_i,
  output logic [REG_W-1:0]                rdata_o,
  output logic [NUM_SETS-1:0][REG_W-1:0]  set_o,
  output logic                            dis_o,
  output logic [2:0]                      slew_o
);
  logic to_def;
  assign to_def = !en_i || (wr_i && idx_i == IDX_CTRL && wdata_i[CTRL_RST_BIT]);

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           set_o[g] <= SET_DEF[g];
      else if (to_def)                       set_o[g] <= SET_DEF[g];
      else if (wr_i && idx_i == REG_W'(g))   set_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_o <= DIS_DEF; slew_o <= SLEW_DEF;
    end else if (to_def) begin
      dis_o <= DIS_DEF; slew_o <= SLEW_DEF;
    end else if (wr_i && idx_i == IDX_CTRL) begin
      dis_o <= wdata_i[7]; slew_o <= wdata_i[6:4];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i < REG_W'(NUM_SETS)) rdata_o = set_o[idx_i[0]];
    else begin
      unique case (idx_i)
        IDX_CTRL: rdata_o = {dis_o, slew_o, 4'b0000};
        IDX_VEND: rdata_o = ID_VEND;
        IDX_REV:  rdata_o = ID_REV;
        IDX_STAT: rdata_o = {pgood_i, 7'b0};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vreg_cfg_i2c.sv
`timescale 1ns/1ps
module vreg_cfg_i2c
  import vreg_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h60,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       pgood_i,
  output logic       sda_pull_o,
  output logic       buck0_on_o,
  output logic       pwm0_force_o,
  output logic [5:0] vcode0_o,
  output logic       buck1_on_o,
  output logic       pwm1_force_o,
  output logic [5:0] vcode1_o,
  output logic       discharge_o,
  output logic [2:0] slew_o
);
  logic sda_s, rise, fall, start, stop, wr;
  logic [REG_W-1:0] idx, wdata, rdata;
  logic [NUM_SETS-1:0][REG_W-1:0] sets;

  vreg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  vreg_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i, .rst_ni, .en_i, .sda_i(sda_s),
    .scl_rise_i(rise), .scl_fall_i(fall), .start_i(start), .stop_i(stop),
    .rdata_i(rdata), .sda_pull_o, .wr_o(wr), .idx_o(idx), .wdata_o(wdata)
  );

  vreg_reg_bank u_bank (
    .clk_i, .rst_ni, .en_i, .wr_i(wr), .idx_i(idx), .wdata_i(wdata),
    .pgood_i, .rdata_o(rdata), .set_o(sets), .dis_o(discharge_o), .slew_o
  );

  assign {buck0_on_o, pwm0_force_o, vcode0_o} = sets[0];
  assign {buck1_on_o, pwm1_force_o, vcode1_o} = sets[1];
endmodule

// File: rtl/vreg_cfg_i2c_chk.sv
`timescale 1ns/1ps
module vreg_cfg_i2c_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       buck0_on_o,
  input logic       pwm0_force_o,
  input logic [5:0] vcode0_o,
  input logic       buck1_on_o,
  input logic       pwm1_force_o,
  input logic [5:0] vcode1_o,
  input logic       discharge_o,
  input logic [2:0] slew_o
);
  a_r11_no_pull_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i)) |-> !sda_pull_o);

  a_r11_defaults_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ({buck0_on_o, pwm0_force_o, vcode0_o} == 8'h28 &&
               {buck1_on_o, pwm1_force_o, vcode1_o} == 8'hAC &&
               discharge_o && slew_o == 3'b000));

  a_r12_pull_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !$stable(sda_pull_o)) |-> !scl_i);

  a_r2_fields_move_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable({vcode0_o, vcode1_o, slew_o})) |-> !scl_i);
endmodule

bind vreg_cfg_i2c vreg_cfg_i2c_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_i(scl_i),
  .sda_pull_o(sda_pull_o), .buck0_on_o(buck0_on_o), .pwm0_force_o(pwm0_force_o),
  .vcode0_o(vcode0_o), .buck1_on_o(buck1_on_o), .pwm1_force_o(pwm1_force_o),
  .vcode1_o(vcode1_o), .discharge_o(discharge_o), .slew_o(slew_o)
);

// File: tb/vreg_cfg_i2c_tb_top.sv
`timescale 1ns/1ps
module vreg_cfg_i2c_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, en = 1'b1, pgood = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, b0, p0, b1, p1, dis;
  logic [5:0] c0, c1;
  logic [2:0] slew;
  wire sda_bus = sda_m & ~sda_pull;
  int vec = 0, err = 0;
  logic [7:0] m0 = 8'h28, m1 = 8'hAC, mc = 8'h80;

  always #5 clk = ~clk;

  vreg_cfg_i2c dut_i (
    .clk_i(clk), .rst_ni, .en_i(en), .scl_i(scl_m), .sda_i(sda_bus), .pgood_i(pgood),
    .sda_pull_o(sda_pull), .buck0_on_o(b0), .pwm0_force_o(p0), .vcode0_o(c0),
    .buck1_on_o(b1), .pwm1_force_o(p1), .vcode1_o(c1), .discharge_o(dis), .slew_o(slew)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic half();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic i2c_rstart();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; half(); ack = sda_bus; half(); scl_m = 0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1; half(); b = {b[6:0], sda_bus}; half(); scl_m = 0;
    end
    q(); sda_m = 1; q(); scl_m = 1; q(); scl_m = 0; q();
  endtask

  task automatic wr(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] d,
                    output logic [2:0] acks);
    i2c_start();
    send_byte(dev, acks[2]); send_byte(idx, acks[1]); send_byte(d, acks[0]);
    i2c_stop();
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d, output logic [2:0] acks);
    i2c_start();
    send_byte(8'hC0, acks[2]); send_byte(idx, acks[1]);
    i2c_rstart();
    send_byte(8'hC1, acks[0]);
    recv_byte(d);
    i2c_stop();
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m0;
      8'h01: return m1;
      8'h02: return mc;
      8'h03: return 8'h80;
      8'h04: return 8'h01;
      8'h05: return {pgood, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_outs(input string tag);
    chk({tag, " set0"}, {b0, p0, c0}, m0);
    chk({tag, " set1"}, {b1, p1, c1}, m1);
    chk({tag, " ctrl"}, {dis, slew, 4'b0}, mc);
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] idx);
    logic [7:0] d; logic [2:0] a;
    rd(idx, d, a);
    chk({tag, " read acks"}, {5'b0, a}, 8'h00);
    chk({tag, " read data"}, d, exp_rd(idx));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [2:0] a;
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #2 rst_ni = 1;
    q();
    chk_outs("R1 reset");
    for (int i = 0; i < 8; i++) chk_rd("R3 R6 R7 R8 default", 8'(i));

    for (int i = 0; i < 8; i++) begin
      v = 8'(i * 37 + 3);
      wr(8'hC0, 8'h00, v, a); m0 = v;
      chk("R2 acks set0", {5'b0, a}, 8'h00);
      chk_outs("R2 set0");
      chk_rd("R3 set0", 8'h00);
      wr(8'hC0, 8'h01, v ^ 8'hA5, a); m1 = v ^ 8'hA5;
      chk_outs("R2 set1");
      chk_rd("R3 set1", 8'h01);
    end

    for (int i = 0; i < 8; i++) begin
      v = {~i[0], 3'(i), 4'b1011};
      wr(8'hC0, 8'h02, v, a); mc = {v[7:4], 4'b0};
      chk_outs("R4 ctrl");
      chk_rd("R4 ctrl readback", 8'h02);
    end

    for (int i = 3; i < 9; i++) begin
      wr(8'hC0, 8'(i), 8'hFF, a);
      chk("R8 R6 R7 write ack", {5'b0, a}, 8'h00);
      chk_outs("R6 R7 R8 no effect");
      chk_rd("R6 R7 R8 readback", 8'(i));
    end
    chk_rd("R8 high index", 8'hFF);

    pgood = 1; chk_rd("R7 pgood high", 8'h05);
    pgood = 0; chk_rd("R7 pgood low", 8'h05);

    foreach (v[i]) begin
      wr(8'(8'hC2 ^ (8'd1 << i)) ^ 8'h02, 8'h00, 8'h3C, a);
    end
    wr(8'hC2, 8'h00, 8'h3C, a);
    chk("R9 wrong address nack", {7'b0, a[2]}, 8'h01);
    wr(8'hA0, 8'h01, 8'h3C, a);
    chk("R9 wrong address nack", {7'b0, a[2]}, 8'h01);
    chk_outs("R9 no effect");

    i2c_start();
    send_byte(8'h0B, a[2]);
    chk("R10 master code nack", {7'b0, a[2]}, 8'h01);
    i2c_rstart();
    send_byte(8'hC0, a[1]); send_byte(8'h01, a[0]);
    chk("R10 resume acks", {6'b0, a[1:0]}, 8'h00);
    send_byte(8'h5A, a[0]);
    i2c_stop();
    m1 = 8'h5A;
    chk_outs("R10 write after master code");
    chk("R12 released after stop", {7'b0, sda_pull}, 8'h00);

    wr(8'hC0, 8'h00, 8'hC1, a); m0 = 8'hC1;
    wr(8'hC0, 8'h02, 8'h74, a);
    m0 = 8'h28; m1 = 8'hAC; mc = 8'h80;
    chk_outs("R5 soft reset wins over fields");
    chk_rd("R5 ctrl reads zero reset bit", 8'h02);
    chk_rd("R5 set1 default", 8'h01);

    wr(8'hC0, 8'h01, 8'h11, a); wr(8'hC0, 8'h02, 8'h30, a);
    m1 = 8'h11; mc = 8'h30;
    chk_outs("R2 before disable");
    en = 0; q();
    m0 = 8'h28; m1 = 8'hAC; mc = 8'h80;
    chk_outs("R11 defaults while off");
    wr(8'hC0, 8'h00, 8'h3F, a);
    chk("R11 no ack while off", {5'b0, a}, 8'h07);
    chk_outs("R11 write ignored");
    en = 1; q();
    chk_rd("R11 default after enable", 8'h00);
    chk_rd("R11 default after enable", 8'h02);

    summary();
  end
endmodule